// File: doc/BRIEF.md
# BCD Calendar Clock with Alarms

This block keeps wall-clock time and a calendar in packed BCD: seconds, minutes, hours (24-hour), day of week, date, month and a two-digit year standing for 2000 to 2099. A fast base tick feeds an internal prescaler. The prescaler makes one advance per second, and each advance steps the calendar. Rollover follows month length and leap years.

Two alarm units each compare seconds, minutes, hours and date against the time the calendar is about to take. A match raises a sticky status flag. A control register holds the oscillator stop, the interrupt enables and a select bit. The select bit makes the interrupt pin carry either the alarm interrupt or a square wave. A charger register is decoded onto plain pins.

Registers load through a valid/ready write port. The port never applies back-pressure: `wr_ready` is always 1, so every cycle with `wr_valid` high commits one write. Reads are combinational from `rd_addr`.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the time reads 00:00:00, day of week 1, date 01, month 01, year 00. Control reads 0x00, status reads 0x80, charger reads 0x00, alarm registers read 0x00 and `irq_o` is 0.
- R2: Register map:
  - Time registers are 0x00 seconds (mask 0x7F), 0x01 minutes (0x7F), 0x02 hours (0x3F), 0x03 day of week (0x07), 0x04 date (0x3F), 0x05 month (0x1F) and 0x06 year (0xFF).
  - Alarm 0 is at 0x07 to 0x0A and alarm 1 at 0x0B to 0x0E, each holding seconds (0x7F), minutes (0x7F), hours (0x3F) and date (0x3F).
  - Control is at 0x0F and reads with bit 6 as 0. Status is at 0x10. Charger is at 0x11, all 8 bits.
  - Any other address reads 0x00 and ignores writes. `wr_ready` is always 1.
- R3: With the oscillator running, the seconds advance exactly once every TICKS_PER_SEC base ticks.
- R4: Seconds and minutes wrap from 59 to 00 with carry, and hours wrap from 23 to 00. Day of week runs 1 to 7 and returns to 1 when the day changes.
- R5: The date wraps to 01 after the last day of the month: 30 for April, June, September and November, 28 for February (29 when the year is divisible by 4) and 31 otherwise. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R6: While control bit 7 is 1, time does not advance and the prescaler is held at zero. While that bit is 1, status bit 7 (oscillator stopped) is set every cycle, and it is also set by reset.
- R7: A write to any time register restarts the prescaler, so the next advance comes a full TICKS_PER_SEC base ticks later. A base tick in the same cycle as the write is not counted.
- R8: On an advance, alarm N sets status bit N (bit 0 for alarm 0, bit 1 for alarm 1) when the new seconds, minutes, hours and date all equal its registers. Writing the time never sets a flag.
- R9: Status flags are sticky. A status write clears each flag whose bit is written 0 and never sets a flag. A flag set by an event in the same cycle as a clearing write stays set.
- R10: With control bit 2 set, `irq_o` = (flag0 AND control bit 0) OR (flag1 AND control bit 1). With control bit 2 clear, `irq_o` = control bit 3 AND a square level that starts at 0 and toggles on every advance.
- R11: Charger decode: when charger bits 7:4 equal 0xA and bits 1:0 are not 00, `chg_on` is 1, `chg_res` = bits 1:0 and `chg_diode` = bits 3:2. In every other case all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | One-cycle pulse from the fast timebase, TICKS_PER_SEC per second |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Always 1, no back-pressure |
| wr_addr | input | 5 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 5 | Read register address |
| rd_data | output | 8 | Combinational read data |
| irq_o | output | 1 | Alarm interrupt or square wave, active high |
| chg_on | output | 1 | Charger enabled |
| chg_diode | output | 2 | Charger diode setting |
| chg_res | output | 2 | Charger resistor setting |

## Verification
An alarm match and a status write that clears that alarm's flag can fall in the same cycle. The bench provokes this by running the prescaler to one tick before the matching second, then presenting the last base tick together with a status write of 0x00. It judges the result by reading status bit 0 back as 1. A second overlap, a base tick arriving together with a time write, is also driven; the bench checks that the seconds do not move for TICKS_PER_SEC-1 further ticks and then advance exactly once.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] dow;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } rtc_time_t;

  localparam int NUM_ALARMS = 2;

  localparam logic [4:0] A_SEC  = 5'h00;
  localparam logic [4:0] A_MIN  = 5'h01;
  localparam logic [4:0] A_HOUR = 5'h02;
  localparam logic [4:0] A_DOW  = 5'h03;
  localparam logic [4:0] A_DATE = 5'h04;
  localparam logic [4:0] A_MON  = 5'h05;
  localparam logic [4:0] A_YEAR = 5'h06;
  localparam logic [4:0] A_AL0  = 5'h07;
  localparam logic [4:0] A_AL1  = 5'h0B;
  localparam logic [4:0] A_CTRL = 5'h0F;
  localparam logic [4:0] A_STAT = 5'h10;
  localparam logic [4:0] A_CHG  = 5'h11;

  // Control bit positions
  localparam int C_OSC_OFF = 7;
  localparam int C_SQW     = 3;
  localparam int C_INTSEL  = 2;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // 10 is 2 mod 4, so tens*2 + units decides divisibility by 4
  function automatic logic bcd_leap(input logic [7:0] y);
    logic [4:0] t;
    t = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return t[1:0] == 2'b00;
  endfunction

  function automatic logic [5:0] last_day(input logic [4:0] mon, input logic [7:0] year);
    case (mon)
      5'h02:                      return bcd_leap(year) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic base_tick,
  input  logic halt,
  input  logic restart,
  output logic sec_pulse
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || halt)  cnt_q <= '0;
    else if (base_tick)        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign sec_pulse = base_tick && !halt && !restart && (cnt_q == LAST);

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0); // R7
  AST_PULSE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse); // R3

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_core_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  logic      wr_en,
  input  logic [4:0] wr_addr,
  input  logic [7:0] wr_data,
  output rtc_time_t cur_o,
  output rtc_time_t nxt_o
);
  rtc_time_t cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    if (cur_q.sec == 7'h59) begin
      nxt.sec = '0;
      if (cur_q.min == 7'h59) begin
        nxt.min = '0;
        if (cur_q.hour == 6'h23) begin
          nxt.hour = '0;
          nxt.dow  = (cur_q.dow >= 3'd7) ? 3'd1 : cur_q.dow + 3'd1;
          if (cur_q.date == last_day(cur_q.mon, cur_q.year)) begin
            nxt.date = 6'h01;
            if (cur_q.mon == 5'h12) begin
              nxt.mon  = 5'h01;
              nxt.year = (cur_q.year == 8'h99) ? 8'h00 : bcd_inc(cur_q.year);
            end else begin
              nxt.mon = 5'(bcd_inc({3'b000, cur_q.mon}));
            end
          end else begin
            nxt.date = 6'(bcd_inc({2'b00, cur_q.date}));
          end
        end else begin
          nxt.hour = 6'(bcd_inc({2'b00, cur_q.hour}));
        end
      end else begin
        nxt.min = 7'(bcd_inc({1'b0, cur_q.min}));
      end
    end else begin
      nxt.sec = 7'(bcd_inc({1'b0, cur_q.sec}));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q      <= '0;
      cur_q.dow  <= 3'd1;
      cur_q.date <= 6'h01;
      cur_q.mon  <= 5'h01;
    end else if (wr_en) begin
      case (wr_addr)
        A_SEC:   cur_q.sec  <= wr_data[6:0];
        A_MIN:   cur_q.min  <= wr_data[6:0];
        A_HOUR:  cur_q.hour <= wr_data[5:0];
        A_DOW:   cur_q.dow  <= wr_data[2:0];
        A_DATE:  cur_q.date <= wr_data[5:0];
        A_MON:   cur_q.mon  <= wr_data[4:0];
        A_YEAR:  cur_q.year <= wr_data;
        default: ;
      endcase
    end else if (adv) begin
      cur_q <= nxt;
    end
  end

  assign cur_o = cur_q;
  assign nxt_o = nxt;

  AST_TIME_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !wr_en) |=> $stable(cur_q)); // R3
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en && cur_q.sec == 7'h59) |=> cur_q.sec == 7'h00); // R4
  AST_YEAR_END: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en && cur_q.mon == 5'h12 && cur_q.date == 6'h31 && cur_q.hour == 6'h23
     && cur_q.min == 7'h59 && cur_q.sec == 7'h59) |=> (cur_q.mon == 5'h01 && cur_q.date == 6'h01)); // R5

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter logic [4:0] BASE = 5'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] wr_addr,
  input  logic [6:0] wr_data,
  input  logic       adv,
  input  logic [6:0] t_sec,
  input  logic [6:0] t_min,
  input  logic [5:0] t_hour,
  input  logic [5:0] t_date,
  output logic       hit,
  output logic [6:0] a_sec,
  output logic [6:0] a_min,
  output logic [5:0] a_hour,
  output logic [5:0] a_date
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sec <= '0; a_min <= '0; a_hour <= '0; a_date <= '0;
    end else if (wr_en) begin
      if (wr_addr == BASE)         a_sec  <= wr_data;
      if (wr_addr == BASE + 5'd1)  a_min  <= wr_data;
      if (wr_addr == BASE + 5'd2)  a_hour <= wr_data[5:0];
      if (wr_addr == BASE + 5'd3)  a_date <= wr_data[5:0];
    end
  end

  assign hit = adv && (t_sec == a_sec) && (t_min == a_min)
                   && (t_hour == a_hour) && (t_date == a_date);

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_core_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_tick,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [4:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [4:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq_o,
  output logic       chg_on,
  output logic [1:0] chg_diode,
  output logic [1:0] chg_res
);
  logic       wr_fire, time_wr, stat_wr, sec_pulse, osc_off;
  logic [7:0] ctrl_q, chg_q;
  logic       osf_q, sq_q;
  logic [NUM_ALARMS-1:0] af_q, al_hit;
  logic [6:0] al_sec  [NUM_ALARMS];
  logic [6:0] al_min  [NUM_ALARMS];
  logic [5:0] al_hour [NUM_ALARMS];
  logic [5:0] al_date [NUM_ALARMS];
  rtc_time_t  cur, nxt;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;
  assign time_wr  = wr_fire && (wr_addr <= A_YEAR);
  assign stat_wr  = wr_fire && (wr_addr == A_STAT);
  assign osc_off  = ctrl_q[C_OSC_OFF];

  rtc_prescaler #(.DIV(TICKS_PER_SEC)) u_presc (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
    .halt(osc_off), .restart(time_wr), .sec_pulse(sec_pulse)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .adv(sec_pulse), .wr_en(time_wr),
    .wr_addr(wr_addr), .wr_data(wr_data), .cur_o(cur), .nxt_o(nxt)
  );

  for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alarm
    rtc_alarm #(.BASE(A_AL0 + 5'(4 * g))) u_alarm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .wr_addr(wr_addr),
      .wr_data(wr_data[6:0]), .adv(sec_pulse),
      .t_sec(nxt.sec), .t_min(nxt.min), .t_hour(nxt.hour), .t_date(nxt.date),
      .hit(al_hit[g]), .a_sec(al_sec[g]), .a_min(al_min[g]),
      .a_hour(al_hour[g]), .a_date(al_date[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      chg_q  <= '0;
      osf_q  <= 1'b1;
      af_q   <= '0;
      sq_q   <= 1'b0;
    end else begin
      if (wr_fire && wr_addr == A_CTRL) ctrl_q <= wr_data & 8'hBF;
      if (wr_fire && wr_addr == A_CHG)  chg_q  <= wr_data;
      osf_q <= (stat_wr ? (osf_q & wr_data[7]) : osf_q) | osc_off;
      af_q  <= (stat_wr ? (af_q & wr_data[NUM_ALARMS-1:0]) : af_q) | al_hit;
      if (sec_pulse) sq_q <= ~sq_q;
    end
  end

  assign irq_o = ctrl_q[C_INTSEL] ? |(af_q & ctrl_q[NUM_ALARMS-1:0])
                                  : (ctrl_q[C_SQW] & sq_q);

  always_comb begin
    chg_on    = (chg_q[7:4] == 4'hA) && (chg_q[1:0] != 2'b00);
    chg_res   = chg_on ? chg_q[1:0] : 2'b00;
    chg_diode = chg_on ? chg_q[3:2] : 2'b00;
  end

  always_comb begin
    case (rd_addr)
      A_SEC:          rd_data = {1'b0, cur.sec};
      A_MIN:          rd_data = {1'b0, cur.min};
      A_HOUR:         rd_data = {2'b0, cur.hour};
      A_DOW:          rd_data = {5'b0, cur.dow};
      A_DATE:         rd_data = {2'b0, cur.date};
      A_MON:          rd_data = {3'b0, cur.mon};
      A_YEAR:         rd_data = cur.year;
      A_AL0:          rd_data = {1'b0, al_sec[0]};
      A_AL0 + 5'd1:   rd_data = {1'b0, al_min[0]};
      A_AL0 + 5'd2:   rd_data = {2'b0, al_hour[0]};
      A_AL0 + 5'd3:   rd_data = {2'b0, al_date[0]};
      A_AL1:          rd_data = {1'b0, al_sec[1]};
      A_AL1 + 5'd1:   rd_data = {1'b0, al_min[1]};
      A_AL1 + 5'd2:   rd_data = {2'b0, al_hour[1]};
      A_AL1 + 5'd3:   rd_data = {2'b0, al_date[1]};
      A_CTRL:         rd_data = ctrl_q;
      A_STAT:         rd_data = {osf_q, 5'b0, af_q};
      A_CHG:          rd_data = chg_q;
      default:        rd_data = 8'h00;
    endcase
  end

  AST_OSF_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off |=> osf_q); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (af_q[0] && !stat_wr) |=> af_q[0]); // R9
  AST_MATCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    al_hit[1] |=> af_q[1]); // R8
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[C_INTSEL] && ctrl_q[1:0] == 2'b00) |-> !irq_o); // R10
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready); // R2

endmodule

// File: tb/rtc_bcd_core_test.sv
module rtc_bcd_core_test;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_tick = 1'b0, wr_valid = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_ready, irq_o, chg_on;
  logic [7:0] rd_data;
  logic [1:0] chg_diode, chg_res;

  always #5 clk = ~clk;

  rtc_bcd_core #(.TICKS_PER_SEC(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_o(irq_o), .chg_on(chg_on), .chg_diode(chg_diode),
    .chg_res(chg_res)
  );

  int checks = 0, errors = 0;
  int ms, mm, mh, mw, md, mo, my, pc;
  bit m_off = 0;

  function automatic int dim(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] b2b(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic step_model();
    ms++;
    if (ms == 60) begin ms = 0; mm++; end
    if (mm == 60) begin mm = 0; mh++; end
    if (mh == 24) begin
      mh = 0; mw = (mw == 7) ? 1 : mw + 1; md++;
      if (md > dim(mo, my)) begin md = 1; mo++; end
      if (mo == 13) begin mo = 1; my = (my + 1) % 100; end
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rdchk(string tag, logic [4:0] a, logic [7:0] exp);
    rd_addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic tick_model();
    if (m_off) pc = 0;
    else if (pc == DIV - 1) begin pc = 0; step_model(); end
    else pc++;
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 0;
    if (a <= 5'h06) pc = 0;
  endtask

  task automatic tk();
    @(negedge clk); base_tick = 1;
    @(negedge clk); base_tick = 0;
    tick_model();
  endtask

  task automatic wr_tk(logic [4:0] a, logic [7:0] d);
    @(negedge clk); wr_valid = 1; wr_addr = a; wr_data = d; base_tick = 1;
    @(negedge clk); wr_valid = 0; base_tick = 0;
    if (a <= 5'h06) pc = 0; else tick_model();
  endtask

  task automatic secs(int n);
    repeat (n * DIV) tk();
  endtask

  task automatic set_time(int s, int m, int h, int w, int d, int mon, int y);
    wr(5'h00, b2b(s)); wr(5'h01, b2b(m)); wr(5'h02, b2b(h)); wr(5'h03, b2b(w));
    wr(5'h04, b2b(d)); wr(5'h05, b2b(mon)); wr(5'h06, b2b(y));
    ms = s; mm = m; mh = h; mw = w; md = d; mo = mon; my = y; pc = 0;
  endtask

  task automatic chk_time(string tag);
    rdchk({tag, " sec"},  5'h00, b2b(ms));
    rdchk({tag, " min"},  5'h01, b2b(mm));
    rdchk({tag, " hour"}, 5'h02, b2b(mh));
    rdchk({tag, " dow"},  5'h03, b2b(mw));
    rdchk({tag, " date"}, 5'h04, b2b(md));
    rdchk({tag, " mon"},  5'h05, b2b(mo));
    rdchk({tag, " year"}, 5'h06, b2b(my));
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    ms = 0; mm = 0; mh = 0; mw = 1; md = 1; mo = 1; my = 0; pc = 0;
    @(negedge clk);
    // R1 reset state
    chk_time("R1 reset");
    rdchk("R1 ctrl", 5'h0F, 8'h00);
    rdchk("R1 status", 5'h10, 8'h80);
    rdchk("R1 charger", 5'h11, 8'h00);
    rdchk("R1 alarm", 5'h0B, 8'h00);
    chk("R1 irq", irq_o, 0);

    // R2 masks, unused addresses, ready
    chk("R2 ready", wr_ready, 1);
    wr(5'h02, 8'hFF); rdchk("R2 hour mask", 5'h02, 8'h3F);
    wr(5'h03, 8'hFF); rdchk("R2 dow mask", 5'h03, 8'h07);
    wr(5'h0A, 8'hFF); rdchk("R2 alarm date mask", 5'h0A, 8'h3F);
    wr(5'h15, 8'h55); rdchk("R2 unused", 5'h15, 8'h00);
    wr(5'h0F, 8'h7F); rdchk("R2 ctrl bit6", 5'h0F, 8'h3F);
    wr(5'h0F, 8'h00); wr(5'h0A, 8'h00);

    // R9 status clear / no set by write
    wr(5'h10, 8'h00); rdchk("R9 clear osf", 5'h10, 8'h00);
    wr(5'h10, 8'hFF); rdchk("R9 write one no set", 5'h10, 8'h00);

    // R3 prescaler period
    set_time(10, 0, 0, 1, 1, 1, 0);
    repeat (DIV - 1) tk();
    rdchk("R3 before period", 5'h00, 8'h10);
    tk(); rdchk("R3 after period", 5'h00, 8'h11);

    // R4 / R5 rollovers
    set_time(59, 59, 23, 7, 28, 2, 24); secs(1); chk_time("R5 leap feb28");
    set_time(59, 59, 23, 3, 29, 2, 24); secs(1); chk_time("R5 leap feb29");
    set_time(59, 59, 23, 3, 28, 2, 23); secs(1); chk_time("R5 feb28 common");
    set_time(59, 59, 23, 5, 30, 4, 31); secs(1); chk_time("R5 april end");
    set_time(59, 59, 23, 6, 31, 12, 99); secs(1); chk_time("R5 century wrap");
    set_time(58, 59, 9, 2, 15, 7, 40); secs(2); chk_time("R4 hour carry");

    // R7 restart on time write, coincident tick ignored
    set_time(20, 0, 0, 1, 1, 1, 0);
    repeat (DIV - 1) tk();
    wr_tk(5'h00, 8'h30); ms = 30;
    repeat (DIV - 1) tk();
    rdchk("R7 no early advance", 5'h00, 8'h30);
    tk(); rdchk("R7 advance after restart", 5'h00, 8'h31);

    // R6 oscillator stop
    wr(5'h0F, 8'h80); m_off = 1; pc = 0;
    wr(5'h10, 8'h00); rdchk("R6 osf held", 5'h10, 8'h80);
    repeat (3 * DIV) tk();
    rdchk("R6 frozen", 5'h00, 8'h31);
    wr(5'h0F, 8'h00); m_off = 0;
    wr(5'h10, 8'h00); rdchk("R6 osf cleared", 5'h10, 8'h00);
    secs(1); rdchk("R6 resumes", 5'h00, 8'h32);

    // R8 alarm 0, R10 interrupt
    wr(5'h07, 8'h10); wr(5'h08, 8'h00); wr(5'h09, 8'h00); wr(5'h0A, 8'h05);
    wr(5'h0F, 8'h05); wr(5'h10, 8'h00);
    set_time(10, 0, 0, 1, 5, 1, 0);
    rdchk("R8 no match on write", 5'h10, 8'h00);
    set_time(9, 0, 0, 1, 5, 1, 0);
    secs(1);
    rdchk("R8 alarm0 flag", 5'h10, 8'h01);
    chk("R10 irq alarm0", irq_o, 1);
    wr(5'h10, 8'h00);
    rdchk("R9 flag cleared", 5'h10, 8'h00);
    chk("R10 irq drops", irq_o, 0);

    // R9 match and clear in the same cycle
    set_time(9, 0, 0, 1, 5, 1, 0);
    repeat (DIV - 1) tk();
    wr_tk(5'h10, 8'h00);
    rdchk("R9 set beats clear", 5'h10, 8'h01);
    wr(5'h10, 8'h00);

    // R8 alarm 1, R10 masking
    wr(5'h0B, 8'h30); wr(5'h0C, 8'h15); wr(5'h0D, 8'h07); wr(5'h0E, 8'h12);
    wr(5'h0F, 8'h05);
    set_time(29, 15, 7, 3, 12, 6, 25);
    secs(1);
    rdchk("R8 alarm1 flag", 5'h10, 8'h02);
    chk("R10 irq masked", irq_o, 0);
    wr(5'h0F, 8'h06);
    chk("R10 irq alarm1", irq_o, 1);
    wr(5'h10, 8'h00);

    // R10 square wave
    wr(5'h0F, 8'h08);
    p = irq_o;
    secs(1); chk("R10 square toggles", irq_o, p ^ 1);
    secs(1); chk("R10 square back", irq_o, p);
    wr(5'h0F, 8'h00); chk("R10 square off", irq_o, 0);

    // R11 charger decode
    wr(5'h11, 8'hA9); #1;
    chk("R11 on", chg_on, 1); chk("R11 res", chg_res, 1); chk("R11 diode", chg_diode, 2);
    wr(5'h11, 8'hA8); #1; chk("R11 zero resistor", chg_on, 0); chk("R11 res off", chg_res, 0);
    wr(5'h11, 8'h5B); #1; chk("R11 bad nibble", chg_on, 0); chk("R11 diode off", chg_diode, 0);

    // R4 R5 random runs against the bench model
    for (int i = 0; i < 24; i++) begin
      int s, m, h, w, d, mon, y;
      mon = 1 + $urandom_range(11);
      y = $urandom_range(99);
      d = ($urandom_range(1) == 1) ? dim(mon, y) : 1 + $urandom_range(dim(mon, y) - 1);
      h = ($urandom_range(1) == 1) ? 23 : $urandom_range(23);
      m = ($urandom_range(1) == 1) ? 59 : $urandom_range(59);
      s = 40 + $urandom_range(19);
      w = 1 + $urandom_range(6);
      set_time(s, m, h, w, d, mon, y);
      repeat ($urandom_range(150) * DIV + $urandom_range(DIV - 1)) tk();
      chk_time("R4 R5 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule